// File: doc/BRIEF.md
# Half-Duplex Asynchronous Character Framer

This block turns a parallel byte into a ten-bit asynchronous character on a single serial wire. The wire is shared in both directions. A low start bit leads the frame, eight data bits follow with the least significant bit first, and a high stop bit closes it. The framer makes the start and stop bits itself, so the byte source only hands over eight data bits. A controller sends a command such as a head-movement step as a series of these characters. It then asks the framer to turn the line around, so that the far end can answer with status characters on the same wire.

While the framer drives the line, the line rests high between characters. When the receive direction is requested, the framer finishes any character in progress. It keeps driving the idle level for one more bit time and then releases the driver. In receive direction it watches for a falling start edge, samples each bit at its middle, and presents the recovered byte with a one-cycle strobe. A low stop bit is reported as a framing error. Bit timing comes from a fixed count of clock cycles per bit.

Top module: `half_duplex_framer`

## Requirements
- R1: After reset, line_oe is 1, line_out is 1, tx_busy is 0 and rx_valid is 0. Whenever the driver is enabled and no character is being sent, line_out is 1.
- R2: A byte accepted on a clock edge goes out starting in the next cycle as 10 bits of CLKS_PER_BIT cycles each: start bit 0, data bit 0 first through data bit 7, then stop bit 1.
- R3: tx_busy is 1 from the cycle after an accepted load through the last cycle of its stop bit. A tx_load while tx_busy is 1 is ignored, and no extra character appears on the line.
- R4: Loads issued as soon as tx_busy falls produce consecutive characters, each carrying its own byte in order.
- R5: When rx_req is 1, line_oe stays 1 and line_out stays 1 for exactly CLKS_PER_BIT cycles after the last stop-bit cycle, and line_oe is 0 in the cycle that follows.
- R6: While rx_req is 1 or line_oe is 0, tx_busy is 1 and tx_load has no effect.
- R7: With line_oe at 0, a well-formed character on line_in (start 0, LSB first, stop 1) gives one single-cycle rx_valid pulse with rx_data equal to the byte and rx_frame_err at 0.
- R8: A character whose stop bit is 0 still gives an rx_valid pulse carrying its data bits, with rx_frame_err at 1. rx_frame_err is never 1 without rx_valid.
- R9: A low pulse on line_in shorter than half a bit time is not taken as a start bit and gives no rx_valid.
- R10: While line_oe is 1, activity on line_in gives no rx_valid.
- R11: When rx_req returns to 0 while line_oe is 0, line_oe is 1 in the next cycle and tx_busy is 0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | DATA_BITS | Byte to send |
| tx_load | input | 1 | Load request; accepted when tx_busy is 0 |
| tx_busy | output | 1 | Transmitter cannot accept a byte |
| rx_req | input | 1 | 1 requests receive direction, 0 requests transmit direction |
| line_in | input | 1 | Level seen on the shared wire |
| line_out | output | 1 | Level driven onto the wire |
| line_oe | output | 1 | Driver enable for line_out |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_frame_err | output | 1 | Stop bit of the strobed character was low |

## Verification
The transmitter is tried with 0xA5 and 0x5A, whose alternating bits would show a shifted bit position. It is also tried with 0x01 and 0x80, which tell LSB-first order from MSB-first, and with 0x00 and 0xFF, which show the framing bits against flat data. Back-to-back loads show that there is no missing or extra gap between characters. A load attempted during a character shows whether busy is respected. The turnaround is measured cycle by cycle from the start bit of the last character. The receiver gets a clean byte, a byte with a low stop bit, a short glitch and a character sent while the driver is still on. These tell a real start edge from noise and show that the receive path is inactive in transmit direction.

// File: rtl/framer_pkg.sv
package framer_pkg;
    typedef enum logic [1:0] {
        DIR_TX   = 2'd0,
        DIR_HOLD = 2'd1,
        DIR_RX   = 2'd2
    } dir_mode_e;

    typedef enum logic [1:0] {
        RXP_IDLE  = 2'd0,
        RXP_START = 2'd1,
        RXP_DATA  = 2'd2,
        RXP_STOP  = 2'd3
    } rx_phase_e;
endpackage

// File: rtl/framer_tx.sv
module framer_tx #(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [DATA_BITS-1:0] data,
    output logic                 active,
    output logic                 line
);
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int CW         = $clog2(CLKS_PER_BIT);
    localparam int BW         = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic                  active;
        logic [FRAME_BITS-1:0] frame;
        logic [CW-1:0]         cnt;
        logic [BW-1:0]         left;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.cnt == CW'(CLKS_PER_BIT - 1)) begin
                st_d.cnt   = '0;
                st_d.frame = {1'b1, st_q.frame[FRAME_BITS-1:1]};
                st_d.left  = st_q.left - BW'(1);
                if (st_q.left == BW'(1)) begin
                    st_d.active = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else if (accept) begin
            st_d.active = 1'b1;
            st_d.frame  = {1'b1, data, 1'b0};
            st_d.cnt    = '0;
            st_d.left   = BW'(FRAME_BITS);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, frame: '1, cnt: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign line   = st_q.active ? st_q.frame[0] : 1'b1;
endmodule

// File: rtl/framer_dir.sv
module framer_dir #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_req,
    input  logic tx_active,
    output logic drive_en,
    output logic rx_run,
    output logic tx_ok
);
    import framer_pkg::*;

    localparam int CW = $clog2(CLKS_PER_BIT);

    typedef struct packed {
        dir_mode_e     mode;
        logic [CW-1:0] cnt;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            DIR_TX: begin
                if (rx_req && !tx_active) begin
                    st_d.mode = DIR_HOLD;
                    st_d.cnt  = '0;
                end
            end
            DIR_HOLD: begin
                if (!rx_req) begin
                    st_d.mode = DIR_TX;
                end else if (st_q.cnt == CW'(CLKS_PER_BIT - 2)) begin
                    st_d.mode = DIR_RX;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            DIR_RX: begin
                if (!rx_req) begin
                    st_d.mode = DIR_TX;
                end
            end
            default: st_d.mode = DIR_TX;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: DIR_TX, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_en = (st_q.mode != DIR_RX);
    assign rx_run   = (st_q.mode == DIR_RX) && rx_req;
    assign tx_ok    = (st_q.mode == DIR_TX) && !rx_req;
endmodule

// File: rtl/framer_rx.sv
module framer_rx #(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 line,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid,
    output logic                 frame_err
);
    import framer_pkg::*;

    localparam int CW   = $clog2(CLKS_PER_BIT);
    localparam int HALF = CLKS_PER_BIT / 2;
    localparam int NW   = $clog2(DATA_BITS);

    typedef struct packed {
        logic [2:0]           sync;
        rx_phase_e            phase;
        logic [CW-1:0]        cnt;
        logic [NW-1:0]        nbit;
        logic [DATA_BITS-1:0] shreg;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 err;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      cur, prev;

    assign cur  = st_q.sync[1];
    assign prev = st_q.sync[2];

    always_comb begin
        st_d       = st_q;
        st_d.sync  = {st_q.sync[1:0], line};
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        if (!run) begin
            st_d.phase = RXP_IDLE;
        end else begin
            unique case (st_q.phase)
                RXP_IDLE: begin
                    if (prev && !cur) begin
                        st_d.phase = RXP_START;
                        st_d.cnt   = '0;
                    end
                end
                RXP_START: begin
                    if (st_q.cnt == CW'(HALF - 1)) begin
                        st_d.cnt   = '0;
                        st_d.nbit  = '0;
                        st_d.phase = cur ? RXP_IDLE : RXP_DATA;
                    end else begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end
                RXP_DATA: begin
                    if (st_q.cnt == CW'(CLKS_PER_BIT - 1)) begin
                        st_d.cnt   = '0;
                        st_d.shreg = {cur, st_q.shreg[DATA_BITS-1:1]};
                        st_d.nbit  = st_q.nbit + NW'(1);
                        if (st_q.nbit == NW'(DATA_BITS - 1)) begin
                            st_d.phase = RXP_STOP;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end
                RXP_STOP: begin
                    if (st_q.cnt == CW'(CLKS_PER_BIT - 1)) begin
                        st_d.phase = RXP_IDLE;
                        st_d.data  = st_q.shreg;
                        st_d.valid = 1'b1;
                        st_d.err   = !cur;
                    end else begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end
                default: st_d.phase = RXP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sync: 3'b111, phase: RXP_IDLE, cnt: '0, nbit: '0,
                      shreg: '0, data: '0, valid: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data      = st_q.data;
    assign valid     = st_q.valid;
    assign frame_err = st_q.err;
endmodule

// File: rtl/half_duplex_framer.sv
module half_duplex_framer #(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_load,
    output logic                 tx_busy,
    input  logic                 rx_req,
    input  logic                 line_in,
    output logic                 line_out,
    output logic                 line_oe,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);
    logic tx_active, tx_ok, rx_run, accept;

    assign accept  = tx_load && tx_ok && !tx_active;
    assign tx_busy = tx_active || !tx_ok;

    framer_dir #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_req    (rx_req),
        .tx_active (tx_active),
        .drive_en  (line_oe),
        .rx_run    (rx_run),
        .tx_ok     (tx_ok)
    );

    framer_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .data   (tx_data),
        .active (tx_active),
        .line   (line_out)
    );

    framer_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (rx_run),
        .line      (line_in),
        .data      (rx_data),
        .valid     (rx_valid),
        .frame_err (rx_frame_err)
    );
endmodule

// File: rtl/half_duplex_framer_checker.sv
module half_duplex_framer_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_load,
    input logic tx_busy,
    input logic rx_req,
    input logic line_out,
    input logic line_oe,
    input logic rx_valid,
    input logic rx_frame_err
);
    // R1: idle driven line rests high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !tx_busy) |-> line_out);

    // R2: an accepted load starts a low start bit next cycle
    p_start_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_busy) |=> (!line_out && tx_busy));

    // R6: transmitter blocked while the driver is off
    p_busy_when_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> tx_busy);

    // R7: strobe lasts one cycle
    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: error flag only with a strobe
    p_err_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> rx_valid);

    // R10: no reception while driving
    p_quiet_while_driving_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> !rx_valid);

    // R11: driver returns one cycle after the request drops
    p_oe_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_req && !line_oe) |=> line_oe);
endmodule

bind half_duplex_framer half_duplex_framer_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_load      (tx_load),
    .tx_busy      (tx_busy),
    .rx_req       (rx_req),
    .line_out     (line_out),
    .line_oe      (line_oe),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err)
);

// File: tb/half_duplex_framer_test.sv
module half_duplex_framer_test;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic       tx_busy;
    logic       rx_req = 1'b0;
    logic       line_in;
    logic       line_out;
    logic       line_oe;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;
    logic       far_drv = 1'b1;

    int checks = 0;
    int errors = 0;
    int rx_seen = 0;

    logic [7:0] txq[$];
    logic [8:0] rxq[$];

    always #2 clk = ~clk;

    // wired-AND model of the shared wire
    assign line_in = line_oe ? (line_out & far_drv) : far_drv;

    half_duplex_framer #(.CLKS_PER_BIT(N), .DATA_BITS(8)) uut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_load(tx_load),
        .tx_busy(tx_busy), .rx_req(rx_req), .line_in(line_in),
        .line_out(line_out), .line_oe(line_oe), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // driver: queue expected byte and load it
    task automatic send_byte(input logic [7:0] b);
        while (tx_busy) @(negedge clk);
        tx_data = b;
        tx_load = 1'b1;
        txq.push_back(b);
        @(negedge clk);
        tx_load = 1'b0;
        chk(tx_busy == 1'b1, "R3 busy after load", int'(tx_busy), 1);
        chk(line_out == 1'b0, "R2 start bit next cycle", int'(line_out), 0);
    endtask

    task automatic far_send(input logic [7:0] b, input bit stop_ok, input bit expect_it);
        if (expect_it) rxq.push_back({!stop_ok, b});
        far_drv = 1'b0;
        repeat (N) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            far_drv = b[i];
            repeat (N) @(negedge clk);
        end
        far_drv = stop_ok;
        repeat (N) @(negedge clk);
        far_drv = 1'b1;
        repeat (2 * N) @(negedge clk);
    endtask

    // transmit monitor: decode the line at mid-bit
    initial begin : tx_mon
        logic       prev;
        logic       ok_start;
        logic       ok_stop;
        logic [7:0] got;
        logic [7:0] exp;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && line_oe && prev && !line_out) begin
                repeat (N / 2) @(negedge clk);
                ok_start = !line_out;
                for (int i = 0; i < 8; i++) begin
                    repeat (N) @(negedge clk);
                    got[i] = line_out;
                end
                repeat (N) @(negedge clk);
                ok_stop = line_out;
                chk(ok_start && ok_stop, "R2 framing bits", int'({ok_start, ok_stop}), 3);
                if (txq.size() == 0) begin
                    chk(1'b0, "R3 unexpected character", int'(got), 0);
                end else begin
                    exp = txq.pop_front();
                    chk(got == exp, "R2 R4 data LSB first", int'(got), int'(exp));
                end
            end
            prev = line_out | !line_oe;
        end
    end

    // receive monitor
    initial begin : rx_mon
        logic [8:0] exp;
        forever begin
            @(negedge clk);
            if (rst_n && rx_valid) begin
                rx_seen++;
                if (rxq.size() == 0) begin
                    chk(1'b0, "R9 R10 unexpected rx_valid", int'(rx_data), 0);
                end else begin
                    exp = rxq.pop_front();
                    chk({rx_frame_err, rx_data} == exp, "R7 R8 received char",
                        int'({rx_frame_err, rx_data}), int'(exp));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin : main
        int seen0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(line_oe == 1'b1, "R1 oe", int'(line_oe), 1);
        chk(line_out == 1'b1, "R1 line", int'(line_out), 1);
        chk(tx_busy == 1'b0, "R1 busy", int'(tx_busy), 0);
        chk(rx_valid == 1'b0, "R1 valid", int'(rx_valid), 0);

        // R2 R4 patterns, back to back
        send_byte(8'hA5);
        send_byte(8'h01);
        send_byte(8'h80);
        send_byte(8'hFF);
        send_byte(8'h00);

        // R3 load while busy is ignored
        send_byte(8'h5A);
        repeat (2 * N) @(negedge clk);
        tx_data = 8'hE7;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        while (tx_busy) @(negedge clk);
        chk(line_out == 1'b1, "R3 busy ends after stop", int'(line_out), 1);
        repeat (12 * N) @(negedge clk);

        // R5 turnaround timing, offsets from start-bit cycle
        send_byte(8'h3C);
        repeat (3 * N) @(negedge clk);
        rx_req = 1'b1;
        for (int k = 3 * N + 1; k <= 11 * N; k++) begin
            @(negedge clk);
            if (k == 10 * N) begin
                chk(line_oe == 1'b1 && line_out == 1'b1, "R5 hold after stop",
                    int'({line_oe, line_out}), 3);
            end
            if (k == 11 * N - 1) chk(line_oe == 1'b1, "R5 oe at end of hold", int'(line_oe), 1);
            if (k == 11 * N) chk(line_oe == 1'b0, "R5 oe released", int'(line_oe), 0);
        end
        chk(tx_busy == 1'b1, "R6 busy in receive", int'(tx_busy), 1);
        tx_data = 8'h99;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        chk(line_oe == 1'b0, "R6 load ignored", int'(line_oe), 0);

        // R7 R8 R9 reception
        far_send(8'h5A, 1'b1, 1'b1);
        far_send(8'hC3, 1'b0, 1'b1);
        seen0 = rx_seen;
        far_drv = 1'b0;
        repeat (2) @(negedge clk);
        far_drv = 1'b1;
        repeat (12 * N) @(negedge clk);
        chk(rx_seen == seen0, "R9 glitch ignored", rx_seen, seen0);
        far_send(8'h01, 1'b1, 1'b1);
        far_send(8'h80, 1'b1, 1'b1);
        chk(rxq.size() == 0, "R7 all chars received", rxq.size(), 0);

        // R11 return to transmit
        rx_req = 1'b0;
        @(negedge clk);
        chk(line_oe == 1'b1, "R11 oe back", int'(line_oe), 1);
        chk(tx_busy == 1'b0, "R11 busy cleared", int'(tx_busy), 0);
        send_byte(8'h96);
        while (tx_busy) @(negedge clk);
        repeat (N) @(negedge clk);

        // R10 line activity while driving
        seen0 = rx_seen;
        far_send(8'h42, 1'b1, 1'b0);
        chk(rx_seen == seen0, "R10 no reception while driving", rx_seen, seen0);
        far_drv = 1'b1;

        // R5 idle request releases after one bit time
        rx_req = 1'b1;
        repeat (N - 1) @(negedge clk);
        chk(line_oe == 1'b1, "R5 idle hold", int'(line_oe), 1);
        @(negedge clk);
        chk(line_oe == 1'b0, "R5 idle release", int'(line_oe), 0);
        rx_req = 1'b0;
        repeat (2) @(negedge clk);

        chk(txq.size() == 0, "R2 all chars sent", txq.size(), 0);
        summary();
        $finish;
    end
endmodule